// File: doc/BRIEF.md
# Three-Channel Timer Register Interface

This block is the byte-wide programming front end that sits in front of three independent 16-bit interval counters. A host reaches it over a small register bus with a 2-bit address. Addresses 0, 1 and 2 select a channel's count register, and address 3 takes control words. The block splits each control word into its fields and gives every channel a configuration of its own: an access mode, an operating mode and a counting format. It turns byte writes into full 16-bit count loads. It also runs the latch machinery that gives a stable snapshot of a running counter, and of the channel's configuration and output level, to a host that can only read one byte at a time.

The counters themselves are outside this block. For each channel it drives a one-cycle load strobe with a 16-bit load value, plus the channel's current mode and format fields. It receives each channel's live count and output level. The register bus is a plain strobe interface with no back-pressure: a write or read strobe is acted on in the cycle it is high. Read data is combinational and valid during the read strobe. A read strobe in the same cycle as a write strobe is ignored and has no side effects.

Top module: `tmr_ctl_regs`

## Requirements
- R1: A write to address 3 whose bits 7:6 are 0, 1 or 2 and whose bits 5:4 are nonzero configures that channel: access mode from bits 5:4 (1 low byte only, 2 high byte only, 3 low then high), operating mode from bits 3:1 with codes 6 and 7 folded to 2 and 3, and the format flag from bit 0. The mode and format outputs change in the cycle after the write.
- R2: In the cycle after a count-register write, the channel's load strobe pulses for one cycle. The load value is {8'h00, byte} in low-only mode and {byte, 8'h00} in high-only mode. In low-then-high mode the first byte is held with no strobe, and the second byte loads {second, first}. At most one strobe is high in any cycle.
- R3: A control write with bits 5:4 equal to 0 captures the selected channel's live count into its count latch. If a count latch is already pending, the command is ignored.
- R4: A control write with bits 7:6 equal to 3 is a read-back command. Bit (n+1) selects channel n, and any set of channels may be selected together. Bit 5 low latches the count and bit 4 low latches the status.
- R5: The status byte holds the output level in bit 7, zero in bit 6, the access mode in bits 5:4, the mode in bits 3:1 and the format flag in bit 0. A pending status latch is not overwritten by a later status command.
- R6: A read of a channel returns the pending status first and clears it. Next comes the latched count: one read (low byte, or high byte in high-only mode) releases it, or, in low-then-high mode, a low read then a high read releases it.
- R7: With nothing latched, reads return the live count's low byte in low-only mode and its high byte in high-only mode. In low-then-high mode they alternate, starting with the low byte.
- R8: Configuring a channel's access mode returns both its write and its read byte sequence to the first byte.
- R9: Reading address 3 returns 0 and has no side effect. When no read is active, rdata is 0.
- R10: After reset, every channel is in low-then-high access mode, mode 0, binary format, with no latch pending and no load strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address (0-2 channels, 3 control) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while rd_en is high |
| load_stb | output | 3 | Per-channel count load strobe |
| load_val | output | 48 | Per-channel 16-bit load value, channel n at bits 16n+15:16n |
| mode_o | output | 9 | Per-channel 3-bit operating mode, channel n at bits 3n+2:3n |
| bcd_o | output | 3 | Per-channel counting format flag |
| live_cnt | input | 48 | Per-channel live count from the counters |
| cnt_out | input | 3 | Per-channel counter output level |

## Verification
The assertions check on every cycle that load strobes stay one-hot-or-idle and only ever follow a write to the matching address. They also check that a mode code of 6 or 7 never appears at a channel, that a configuring control word shows up on the mode and format outputs one cycle later, and that the control address reads as zero. The latch and read-order behaviour can only be shown by the bench's scenarios, because it depends on sequences of several commands and reads: status before count, two-byte release, pending latches that refuse to be overwritten, and toggles that restart on reconfiguration.

// File: rtl/tmr_regs_pkg.sv
package tmr_regs_pkg;
  localparam int NUM_CH = 3;
  localparam int MODE_W = 3;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_WORD  = 2'd3
  } acc_e;

  typedef struct packed {
    logic [1:0]        sel;
    acc_e              acc;
    logic [MODE_W-1:0] mode;
    logic              bcd;
  } ctrl_t;

  // Codes 6 and 7 alias modes 2 and 3.
  function automatic logic [MODE_W-1:0] fold_mode(input logic [MODE_W-1:0] m);
    return (m[2] && m[1]) ? {1'b0, m[1:0]} : m;
  endfunction
endpackage

// File: rtl/tmr_ctl_decode.sv
module tmr_ctl_decode
  import tmr_regs_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [NUM_CH-1:0] cfg_we,
  output logic [NUM_CH-1:0] data_we,
  output logic [NUM_CH-1:0] cnt_lat_req,
  output logic [NUM_CH-1:0] st_lat_req,
  output acc_e              new_acc,
  output logic [MODE_W-1:0] new_mode,
  output logic              new_bcd
);
  ctrl_t cw;
  logic  is_ctrl, is_rb;

  assign cw       = ctrl_t'(wdata[7:0]);
  assign is_ctrl  = wr_en && (addr == 2'd3);
  assign is_rb    = (cw.sel == 2'd3);
  assign new_acc  = cw.acc;
  assign new_mode = fold_mode(cw.mode);
  assign new_bcd  = cw.bcd;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    logic hit;
    assign hit            = (cw.sel == 2'(i));
    assign data_we[i]     = wr_en && (addr == 2'(i));
    assign cfg_we[i]      = is_ctrl && !is_rb && hit && (cw.acc != ACC_LATCH);
    assign cnt_lat_req[i] = is_ctrl && (is_rb ? (wdata[i+1] && !wdata[5])
                                              : (hit && cw.acc == ACC_LATCH));
    assign st_lat_req[i]  = is_ctrl && is_rb && wdata[i+1] && !wdata[4];
  end
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
  import tmr_regs_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  acc_e              new_acc,
  input  logic [MODE_W-1:0] new_mode,
  input  logic              new_bcd,
  input  logic              data_we,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic              cnt_lat_req,
  input  logic              st_lat_req,
  input  logic              rd_sel,
  input  logic [CNT_W-1:0]  live,
  input  logic              out_lvl,
  output logic              load_stb,
  output logic [CNT_W-1:0]  load_val,
  output logic [MODE_W-1:0] mode_q,
  output logic              bcd_q,
  output logic [BYTE_W-1:0] rbyte
);
  acc_e              acc_q;
  acc_e              lat_q;   // ACC_LATCH encodes "nothing latched"
  logic              wtog_q, rtog_q, st_pend_q;
  logic [BYTE_W-1:0] hold_q, st_q;
  logic [CNT_W-1:0]  lat_val_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q     <= ACC_WORD;
      mode_q    <= '0;
      bcd_q     <= 1'b0;
      wtog_q    <= 1'b0;
      rtog_q    <= 1'b0;
      hold_q    <= '0;
      lat_q     <= ACC_LATCH;
      lat_val_q <= '0;
      st_pend_q <= 1'b0;
      st_q      <= '0;
      load_stb  <= 1'b0;
      load_val  <= '0;
    end else begin
      load_stb <= 1'b0;
      if (cfg_we) begin
        acc_q  <= new_acc;
        mode_q <= new_mode;
        bcd_q  <= new_bcd;
        wtog_q <= 1'b0;
        rtog_q <= 1'b0;
      end
      if (data_we) begin
        unique case (acc_q)
          ACC_LO: begin
            load_val <= {{BYTE_W{1'b0}}, wbyte};
            load_stb <= 1'b1;
          end
          ACC_HI: begin
            load_val <= {wbyte, {BYTE_W{1'b0}}};
            load_stb <= 1'b1;
          end
          ACC_WORD: begin
            if (!wtog_q) begin
              hold_q <= wbyte;
              wtog_q <= 1'b1;
            end else begin
              load_val <= {wbyte, hold_q};
              load_stb <= 1'b1;
              wtog_q   <= 1'b0;
            end
          end
          default: ;
        endcase
      end
      if (cnt_lat_req && lat_q == ACC_LATCH) begin
        lat_val_q <= live;
        lat_q     <= acc_q;
      end
      if (st_lat_req && !st_pend_q) begin
        st_q      <= {out_lvl, 1'b0, acc_q, mode_q, bcd_q};
        st_pend_q <= 1'b1;
      end
      if (rd_sel) begin
        if (st_pend_q)               st_pend_q <= 1'b0;
        else if (lat_q == ACC_WORD)  lat_q <= ACC_HI;
        else if (lat_q != ACC_LATCH) lat_q <= ACC_LATCH;
        else if (acc_q == ACC_WORD)  rtog_q <= ~rtog_q;
      end
    end
  end

  always_comb begin
    if (st_pend_q)
      rbyte = st_q;
    else if (lat_q != ACC_LATCH)
      rbyte = (lat_q == ACC_HI) ? lat_val_q[CNT_W-1:BYTE_W] : lat_val_q[BYTE_W-1:0];
    else if (acc_q == ACC_HI || (acc_q == ACC_WORD && rtog_q))
      rbyte = live[CNT_W-1:BYTE_W];
    else
      rbyte = live[BYTE_W-1:0];
  end
endmodule

// File: rtl/tmr_ctl_regs.sv
module tmr_ctl_regs
  import tmr_regs_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [1:0]               addr,
  input  logic [BYTE_W-1:0]        wdata,
  output logic [BYTE_W-1:0]        rdata,
  output logic [NUM_CH-1:0]        load_stb,
  output logic [NUM_CH*CNT_W-1:0]  load_val,
  output logic [NUM_CH*MODE_W-1:0] mode_o,
  output logic [NUM_CH-1:0]        bcd_o,
  input  logic [NUM_CH*CNT_W-1:0]  live_cnt,
  input  logic [NUM_CH-1:0]        cnt_out
);
  logic [NUM_CH-1:0] cfg_we, data_we, cnt_lat_req, st_lat_req;
  acc_e              new_acc;
  logic [MODE_W-1:0] new_mode;
  logic              new_bcd;
  logic              rd_eff;
  logic [BYTE_W-1:0] rbyte [NUM_CH];

  assign rd_eff = rd_en && !wr_en;

  tmr_ctl_decode #(.BYTE_W(BYTE_W)) dec_i (
    .wr_en, .addr, .wdata,
    .cfg_we, .data_we, .cnt_lat_req, .st_lat_req,
    .new_acc, .new_mode, .new_bcd
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    tmr_chan_regs #(.BYTE_W(BYTE_W)) ch_i (
      .clk, .rst_n,
      .cfg_we      (cfg_we[i]),
      .new_acc, .new_mode, .new_bcd,
      .data_we     (data_we[i]),
      .wbyte       (wdata),
      .cnt_lat_req (cnt_lat_req[i]),
      .st_lat_req  (st_lat_req[i]),
      .rd_sel      (rd_eff && addr == 2'(i)),
      .live        (live_cnt[i*CNT_W +: CNT_W]),
      .out_lvl     (cnt_out[i]),
      .load_stb    (load_stb[i]),
      .load_val    (load_val[i*CNT_W +: CNT_W]),
      .mode_q      (mode_o[i*MODE_W +: MODE_W]),
      .bcd_q       (bcd_o[i]),
      .rbyte       (rbyte[i])
    );
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (rd_eff && addr == 2'(i)) rdata = rbyte[i];
  end
endmodule

// File: rtl/tmr_ctl_regs_chk.sv
module tmr_ctl_regs_chk
  import tmr_regs_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic                     rd_en,
  input logic [1:0]               addr,
  input logic [BYTE_W-1:0]        wdata,
  input logic [BYTE_W-1:0]        rdata,
  input logic [NUM_CH-1:0]        load_stb,
  input logic [NUM_CH*CNT_W-1:0]  load_val,
  input logic [NUM_CH*MODE_W-1:0] mode_o,
  input logic [NUM_CH-1:0]        bcd_o,
  input logic [NUM_CH*CNT_W-1:0]  live_cnt,
  input logic [NUM_CH-1:0]        cnt_out
);
  // R2
  load_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_stb));

  // R9
  ctl_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr == 2'd3) |-> rdata == '0);

  // R9
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == '0);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R2
    load_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_stb[i] |-> $past(wr_en && addr == 2'(i)));

    // R1
    mode_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_o[i*MODE_W+1 +: 2] != 2'b11);

    // R1
    cfg_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd3 && wdata[7:6] == 2'(i) && wdata[5:4] != 2'b00)
      |=> (bcd_o[i] == $past(wdata[0]) &&
           mode_o[i*MODE_W +: MODE_W] == fold_mode($past(wdata[3:1]))));
  end
endmodule

bind tmr_ctl_regs tmr_ctl_regs_chk #(.BYTE_W(BYTE_W)) chk_i (.*);

// File: tb/tmr_ctl_regs_tb.sv
module tmr_ctl_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [2:0]  load_stb;
  logic [47:0] load_val;
  logic [8:0]  mode_o;
  logic [2:0]  bcd_o;
  logic [15:0] live [3];
  logic [2:0]  cnt_out = '0;
  int nvec = 0, nerr = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tmr_ctl_regs dut_i (
    .clk, .rst_n, .wr_en, .rd_en, .addr, .wdata, .rdata,
    .load_stb, .load_val, .mode_o, .bcd_o,
    .live_cnt ({live[2], live[1], live[0]}), .cnt_out
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] fold(input logic [2:0] m);
    return (m >= 3'd6) ? m - 3'd4 : m;
  endfunction

  // Write one byte; returns after the cycle in which any load strobe is visible.
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wr_load(input int ch, input logic [7:0] d, input bit exp_stb,
                         input logic [15:0] exp_val);
    wr(2'(ch), d);
    chk("R2 strobe", 16'(load_stb), exp_stb ? 16'(3'b001 << ch) : 16'h0);
    if (exp_stb) chk("R2 value", load_val[ch*16 +: 16], exp_val);
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 chk(tag, 16'(rdata), 16'(exp));
    @(negedge clk); rd_en = 1'b0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    live[0] = 16'h0000; live[1] = 16'h0000; live[2] = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 mode", 16'(mode_o), 16'h0);
    chk("R10 bcd", 16'(bcd_o), 16'h0);
    chk("R10 strobe", 16'(load_stb), 16'h0);
    chk("R9 idle rdata", 16'(rdata), 16'h0);
    live[1] = 16'hBEEF;
    rd(2'd1, 8'hEF, "R10 word low first");
    rd(2'd1, 8'hBE, "R10 word high second");
    rd(2'd3, 8'h00, "R9 control read");

    // Sweep every channel, access mode, mode code and format flag.
    for (int ch = 0; ch < 3; ch++)
      for (int acc = 1; acc < 4; acc++)
        for (int m = 0; m < 8; m++)
          for (int b = 0; b < 2; b++) begin
            logic [7:0]  cw;
            logic [15:0] v;
            logic [2:0]  fm;
            cw = {2'(ch), 2'(acc), 3'(m), 1'(b)};
            v  = {cw ^ 8'h5A, cw + 8'h33};
            fm = fold(3'(m));
            wr(2'd3, cw);
            chk("R1 mode", 16'(mode_o[ch*3 +: 3]), 16'(fm));
            chk("R1 bcd", 16'(bcd_o[ch]), 16'(b));
            chk("R2 no strobe on control", 16'(load_stb), 16'h0);
            case (acc)
              1: wr_load(ch, v[7:0], 1'b1, {8'h00, v[7:0]});
              2: wr_load(ch, v[15:8], 1'b1, {v[15:8], 8'h00});
              default: begin
                wr_load(ch, v[7:0], 1'b0, 16'h0);
                wr_load(ch, v[15:8], 1'b1, v);
              end
            endcase
            live[ch] = ~v;
            cnt_out[ch] = 1'(m) ^ 1'(b);
            // R4 status-only read-back of this channel; R5 layout
            wr(2'd3, 8'hE0 | 8'(2 << ch));
            live[ch] = v;
            rd(2'(ch), {cnt_out[ch], 1'b0, 2'(acc), fm, 1'(b)}, "R5 status byte");
            // R7 unlatched reads
            case (acc)
              1: rd(2'(ch), v[7:0], "R7 low only");
              2: rd(2'(ch), v[15:8], "R7 high only");
              default: begin
                rd(2'(ch), v[7:0], "R7 word low");
                rd(2'(ch), v[15:8], "R7 word high");
              end
            endcase
            // R3 counter latch, then R6 latched reads and release
            wr(2'd3, {2'(ch), 6'b000000});
            live[ch] = ~v;
            case (acc)
              1: begin
                rd(2'(ch), v[7:0], "R6 latched low");
                rd(2'(ch), ~v[7:0], "R6 released live low");
              end
              2: begin
                rd(2'(ch), v[15:8], "R6 latched high");
                rd(2'(ch), ~v[15:8], "R6 released live high");
              end
              default: begin
                rd(2'(ch), v[7:0], "R6 latched word low");
                rd(2'(ch), v[15:8], "R6 latched word high");
                rd(2'(ch), ~v[7:0], "R6 released live low");
              end
            endcase
          end

    // R4 multi-channel read-back with R6 status-before-count priority
    wr(2'd3, 8'b00_11_0000);   // ch0 word, mode 0
    wr(2'd3, 8'b01_01_0000);   // ch1 low only
    wr(2'd3, 8'b10_01_0100);   // ch2 low only, mode 2
    live[0] = 16'h1234; live[1] = 16'h0055; live[2] = 16'h00AB;
    cnt_out = 3'b101;
    wr(2'd3, 8'hCA);           // count and status for ch0 and ch2
    live[0] = 16'h9876; live[2] = 16'h00CD; cnt_out = 3'b000;
    wr(2'd3, 8'hEA);           // status again: must not overwrite (R5)
    rd(2'd0, 8'hB0, "R5 status kept ch0");
    rd(2'd0, 8'h34, "R6 latched low ch0");
    rd(2'd0, 8'h12, "R6 latched high ch0");
    rd(2'd0, 8'h76, "R6 live after release ch0");
    rd(2'd1, 8'h55, "R4 unselected ch1 live");
    rd(2'd2, 8'h94, "R5 status kept ch2");
    rd(2'd2, 8'hAB, "R6 latched ch2");
    rd(2'd2, 8'hCD, "R6 live ch2");

    // R3 pending count latch not overwritten
    live[1] = 16'h00F0;
    wr(2'd3, 8'b01_00_0000);
    live[1] = 16'h0011;
    wr(2'd3, 8'b01_00_0000);
    rd(2'd1, 8'hF0, "R3 first latch kept");
    rd(2'd1, 8'h11, "R3 live after release");

    // R8 reconfiguration restarts write and read sequences
    wr_load(0, 8'h11, 1'b0, 16'h0);
    wr(2'd3, 8'b00_11_0000);
    wr_load(0, 8'h22, 1'b0, 16'h0);
    wr_load(0, 8'h33, 1'b1, 16'h3322);
    live[0] = 16'hA1B2;
    rd(2'd0, 8'hB2, "R8 read low");
    wr(2'd3, 8'b00_11_0000);
    rd(2'd0, 8'hB2, "R8 read restarts low");
    rd(2'd3, 8'h00, "R9 control read late");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule